// File: doc/BRIEF.md
# Two-Source Interrupt Request Arbiter

This block sits in front of a small processor core and turns two external interrupt lines into a single pending request. It also supplies an 8-bit type number that the core uses to pick a handler. The first line is non-maskable. It may change at any time relative to the clock, so it passes through a multi-flop synchroniser. It counts only on a rising transition that stays high for a minimum number of clocks, and it cannot be switched off by software. The second line is maskable and level-sensitive. It is registered on the rising clock edge and is considered only on the clock that the core marks as the last of an instruction, and only when the interrupt-enable flag is set at that moment.

Each source latches its own pending state, and that state is released only by the core's acknowledge strobe. When both sources are pending, the non-maskable one is presented and acknowledged first, and the maskable request stays waiting behind it. An acknowledge always retires exactly the source currently on display.

Top module: `dual_irq_ctrl`

## Requirements
- R1: During and after reset, with no stimulus, `irq_req` is 0 and `irq_type` reads 0.
- R2: If `nmi_async` is sampled high on two consecutive rising edges after being low, `irq_req` goes to 1 with `irq_type` = 2 after the third rising edge that follows the first high sample.
- R3: A high level on `nmi_async` that is sampled on only one rising edge never raises a request.
- R4: The non-maskable source raises its request whatever the value of `int_enable`.
- R5: Holding `nmi_async` high gives one request only. After it is acknowledged, no new request comes until the line has gone low and risen again.
- R6: If `insn_done`, `mirq_level` and `int_enable` are all sampled high on the same rising edge, `irq_req` goes to 1 after the following edge. `irq_type` then equals the value of `mirq_type` sampled on that same edge.
- R7: The maskable line raises no request when `int_enable` is low on the boundary edge, or when the line is high only on edges where `insn_done` is low.
- R8: With both sources pending, `irq_type` reads 2. The first `irq_ack` retires the non-maskable source, and the maskable type then appears.
- R9: A pending request stays asserted, with a steady type, until `irq_ack`. An `irq_ack` with nothing pending changes nothing.
- R10: A non-maskable edge that qualifies on the same edge as an acknowledge of the maskable source is kept and presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_async | input | 1 | Non-maskable interrupt line, may be asynchronous |
| mirq_level | input | 1 | Maskable, level-sensitive interrupt line |
| int_enable | input | 1 | Software interrupt-enable flag from the core |
| insn_done | input | 1 | High on the last clock of each instruction |
| irq_ack | input | 1 | One-clock acknowledge of the presented request |
| mirq_type | input | 8 | Type number offered by the maskable source |
| irq_req | output | 1 | A request is pending for the core |
| irq_type | output | 8 | Type number of the presented source, 0 when idle |

## Verification
The properties assume that the core pulses `irq_ack` for one clock at a time and that `insn_done` is a single-clock strobe. The bench drives every input on the falling clock edge, so each input is stable across the rising edge that samples it. The latched-state properties also take for granted that acknowledges come only while a request is shown, except for one deliberate idle acknowledge. That one is checked at the outputs. The non-maskable stimulus always returns low for several clocks between pulses, so each rising edge is seen by the synchroniser as a clean transition.

// File: rtl/irq_pkg.sv
// Package: shared constants and types for the two-source interrupt arbiter.
// Assumes type numbers are at most 8 bits wide.
package irq_pkg;
    localparam int NMI_TYPE_NUM = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_MASK = 2'd2
    } irq_src_e;
endpackage

// File: rtl/irq_sync_chain.sv
// Module: multi-flop synchroniser for a single asynchronous bit.
// Assumes STAGES >= 2; output lags the input by STAGES rising edges.
module irq_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_qual.sv
// Module: qualifies a rising edge of the non-maskable line and latches it.
// A rise counts once the synchronised level has been high for MIN_HIGH
// consecutive samples after a low sample. The latch clears only on pend_clr.
// Assumes MIN_HIGH >= 2. A new qualified edge wins over a clear on the same edge.
module nmi_edge_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_async,
    input  logic pend_clr,
    output logic pend
);
    localparam int WIN_W = MIN_HIGH + 1;

    logic                nmi_s;
    logic [MIN_HIGH-1:0] hist_q;
    logic [WIN_W-1:0]    window;
    logic                qualified;

    irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(nmi_async),
        .q_sync (nmi_s)
    );

    // Keep the recent history of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[MIN_HIGH-2:0], nmi_s};
    end

    assign window    = {hist_q, nmi_s};
    assign qualified = (&window[MIN_HIGH-1:0]) && !window[MIN_HIGH];

    // Latch a qualified edge until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (qualified) pend <= 1'b1;
        else if (pend_clr)  pend <= 1'b0;
    end
endmodule

// File: rtl/intr_boundary_sampler.sv
// Module: samples the maskable level line on instruction boundaries.
// The line, enable flag, boundary strobe and offered type are registered on
// every rising edge. One edge later a boundary sample with line and enable
// high latches the request and its type. Assumes insn_done is one clock wide.
module intr_boundary_sampler #(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mirq_level,
    input  logic              int_enable,
    input  logic              insn_done,
    input  logic [TYPE_W-1:0] mirq_type,
    input  logic              hold_clr,
    output logic              hold,
    output logic [TYPE_W-1:0] hold_type
);
    logic              lvl_q, ie_q, bnd_q;
    logic [TYPE_W-1:0] type_q;
    logic              take;

    // Register the inputs on the rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            ie_q   <= 1'b0;
            bnd_q  <= 1'b0;
            type_q <= '0;
        end else begin
            lvl_q  <= mirq_level;
            ie_q   <= int_enable;
            bnd_q  <= insn_done;
            type_q <= mirq_type;
        end
    end

    assign take = bnd_q && lvl_q && ie_q;

    // Hold an accepted request and its type until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= 1'b0;
            hold_type <= '0;
        end else if (hold_clr) begin
            hold      <= 1'b0;
        end else if (!hold && take) begin
            hold      <= 1'b1;
            hold_type <= type_q;
        end
    end
endmodule

// File: rtl/irq_priority_sel.sv
// Module: fixed-priority selection between the two pending sources.
// The non-maskable source wins. The acknowledge is routed only to the
// source on display. Purely combinational.
module irq_priority_sel
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              nmi_pend,
    input  logic              mask_hold,
    input  logic [TYPE_W-1:0] mask_type,
    input  logic              ack,
    output logic              req,
    output logic [TYPE_W-1:0] type_out,
    output logic              ack_nmi,
    output logic              ack_mask
);
    irq_src_e src;

    // Pick the winning source.
    always_comb begin
        if (nmi_pend)       src = SRC_NMI;
        else if (mask_hold) src = SRC_MASK;
        else                src = SRC_NONE;
    end

    // Drive the request, the type and the acknowledge routing.
    always_comb begin
        req      = (src != SRC_NONE);
        ack_nmi  = ack && (src == SRC_NMI);
        ack_mask = ack && (src == SRC_MASK);
        case (src)
            SRC_NMI:  type_out = TYPE_W'(NMI_TYPE_NUM);
            SRC_MASK: type_out = mask_type;
            default:  type_out = '0;
        endcase
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
// Module: top of the two-source interrupt arbiter.
// Joins the non-maskable edge qualifier, the maskable boundary sampler and
// the priority selector. Assumes irq_ack is a one-clock strobe from the core.
module dual_irq_ctrl #(
    parameter int TYPE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_async,
    input  logic              mirq_level,
    input  logic              int_enable,
    input  logic              insn_done,
    input  logic              irq_ack,
    input  logic [TYPE_W-1:0] mirq_type,
    output logic              irq_req,
    output logic [TYPE_W-1:0] irq_type
);
    logic              nmi_pend, intr_hold, ack_nmi, ack_mask;
    logic [TYPE_W-1:0] intr_type;

    nmi_edge_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_HIGH(MIN_HIGH)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_async(nmi_async),
        .pend_clr (ack_nmi),
        .pend     (nmi_pend)
    );

    intr_boundary_sampler #(.TYPE_W(TYPE_W)) u_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mirq_level(mirq_level),
        .int_enable(int_enable),
        .insn_done (insn_done),
        .mirq_type (mirq_type),
        .hold_clr  (ack_mask),
        .hold      (intr_hold),
        .hold_type (intr_type)
    );

    irq_priority_sel #(.TYPE_W(TYPE_W)) u_sel (
        .nmi_pend (nmi_pend),
        .mask_hold(intr_hold),
        .mask_type(intr_type),
        .ack      (irq_ack),
        .req      (irq_req),
        .type_out (irq_type),
        .ack_nmi  (ack_nmi),
        .ack_mask (ack_mask)
    );
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
// Module: property checker for dual_irq_ctrl, attached by bind.
// Assumes the core acknowledges with one-clock strobes.
module dual_irq_ctrl_chk #(
    parameter int TYPE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done,
    input logic              int_enable,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [TYPE_W-1:0] irq_type,
    input logic              nmi_pend,
    input logic              intr_hold
);
    // R8: a pending non-maskable source is the one presented
    assert_nmi_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> (irq_req && irq_type == TYPE_W'(irq_pkg::NMI_TYPE_NUM)));

    // R9: the non-maskable latch survives every clock without an acknowledge
    assert_nmi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !irq_ack) |=> nmi_pend);

    // R9: the maskable latch survives every clock without an acknowledge
    assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_hold && !irq_ack) |=> intr_hold);

    // R6: a maskable request starts only from an enabled boundary sample
    assert_mask_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_hold) |-> ($past(insn_done, 2) && $past(int_enable, 2)));

    // R9: a shown request persists while it is not acknowledged
    assert_req_persist_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.TYPE_W(TYPE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .int_enable(int_enable),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_type  (irq_type),
    .nmi_pend  (nmi_pend),
    .intr_hold (intr_hold)
);

// File: tb/dual_irq_ctrl_tb.sv
// Bench: directed scenarios for dual_irq_ctrl. Inputs change on falling edges.
module dual_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_async = 1'b0;
    logic       mirq_level = 1'b0;
    logic       int_enable = 1'b0;
    logic       insn_done = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] mirq_type = 8'h00;
    logic       irq_req;
    logic [7:0] irq_type;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_async (nmi_async),
        .mirq_level(mirq_level),
        .int_enable(int_enable),
        .insn_done (insn_done),
        .irq_ack   (irq_ack),
        .mirq_type (mirq_type),
        .irq_req   (irq_req),
        .irq_type  (irq_type)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic req_e, input logic [7:0] type_e);
        checks++;
        if (irq_req !== req_e || irq_type !== type_e) begin
            errors++;
            $display("FAIL %s: req=%0b type=%02h expected req=%0b type=%02h",
                     tag, irq_req, irq_type, req_e, type_e);
        end
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(4);
        expect_out("R1 in reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        step(3);
        expect_out("R1 after reset", 1'b0, 8'h00);
    endtask

    task automatic t_nmi_basic();
        int_enable = 1'b0;       // R4: enable flag low
        nmi_async = 1'b1;
        step(2);                 // sampled high at two edges
        nmi_async = 1'b0;
        step(1);
        expect_out("R2 not yet", 1'b0, 8'h00);
        step(1);
        expect_out("R2 R4 nmi request", 1'b1, 8'h02);
        pulse_ack();
        expect_out("R2 cleared by ack", 1'b0, 8'h00);
        step(3);
    endtask

    task automatic t_nmi_short();
        nmi_async = 1'b1;
        step(1);
        nmi_async = 1'b0;
        step(6);
        expect_out("R3 short pulse", 1'b0, 8'h00);
    endtask

    task automatic t_nmi_level();
        nmi_async = 1'b1;
        step(4);
        expect_out("R5 first request", 1'b1, 8'h02);
        pulse_ack();
        step(6);
        expect_out("R5 no retrigger", 1'b0, 8'h00);
        nmi_async = 1'b0;
        step(4);
    endtask

    task automatic t_intr_basic();
        int_enable = 1'b1;
        mirq_level = 1'b1;
        mirq_type  = 8'h40;
        insn_done  = 1'b1;
        step(1);
        insn_done  = 1'b0;
        mirq_type  = 8'h99;      // later change must not alter the type
        expect_out("R6 latency", 1'b0, 8'h00);
        step(1);
        expect_out("R6 mask request", 1'b1, 8'h40);
        step(8);
        expect_out("R9 held", 1'b1, 8'h40);
        pulse_ack();
        expect_out("R9 released", 1'b0, 8'h00);
        mirq_level = 1'b0;
        step(2);
    endtask

    task automatic t_intr_masked();
        int_enable = 1'b0;
        mirq_level = 1'b1;
        mirq_type  = 8'h21;
        insn_done  = 1'b1;
        step(1);
        insn_done  = 1'b0;
        step(3);
        expect_out("R7 enable low", 1'b0, 8'h00);
        mirq_level = 1'b0;
        int_enable = 1'b1;
        step(2);
    endtask

    task automatic t_intr_off_boundary();
        int_enable = 1'b1;
        mirq_level = 1'b1;
        step(2);
        mirq_level = 1'b0;
        insn_done  = 1'b1;
        step(1);
        insn_done  = 1'b0;
        step(3);
        expect_out("R7 off boundary", 1'b0, 8'h00);
    endtask

    task automatic t_priority();
        int_enable = 1'b1;
        mirq_level = 1'b1;
        mirq_type  = 8'h33;
        insn_done  = 1'b1;
        nmi_async  = 1'b1;
        step(1);
        insn_done  = 1'b0;
        mirq_level = 1'b0;
        step(1);
        nmi_async  = 1'b0;
        expect_out("R6 mask first", 1'b1, 8'h33);
        step(2);
        expect_out("R8 nmi on top", 1'b1, 8'h02);
        pulse_ack();
        expect_out("R8 mask next", 1'b1, 8'h33);
        pulse_ack();
        expect_out("R8 all clear", 1'b0, 8'h00);
        step(3);
    endtask

    task automatic t_ack_idle();
        pulse_ack();
        step(2);
        expect_out("R9 idle ack", 1'b0, 8'h00);
    endtask

    task automatic t_nmi_on_ack();
        int_enable = 1'b1;
        mirq_level = 1'b1;
        mirq_type  = 8'h55;
        insn_done  = 1'b1;
        step(1);
        insn_done  = 1'b0;
        mirq_level = 1'b0;
        step(1);
        expect_out("R10 mask pending", 1'b1, 8'h55);
        nmi_async = 1'b1;
        step(2);
        nmi_async = 1'b0;
        step(1);
        irq_ack = 1'b1;          // acknowledge on the qualifying edge
        step(1);
        irq_ack = 1'b0;
        expect_out("R10 nmi kept", 1'b1, 8'h02);
        pulse_ack();
        expect_out("R10 done", 1'b0, 8'h00);
        step(3);
    endtask

    initial begin
        step(1);
        t_reset();
        t_nmi_basic();
        t_nmi_short();
        t_nmi_level();
        t_intr_basic();
        t_intr_masked();
        t_intr_off_boundary();
        t_priority();
        t_ack_idle();
        t_nmi_on_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule